// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock Core

This core keeps the time of day and the calendar date as packed BCD bytes. It advances once per second, where a second is a fixed number of pulses on a tick input, and it carries seconds into minutes, hours, day of month, month, year and weekday. The length of each month and the leap-year rule are built in.

Software reaches the core through a byte-wide register port. The port has a request strobe, a write enable, an address, write data, and registered read data. A burst flag makes an access use the previous address plus one. Software halts counting with a control bit, loads the time fields, and then restarts. A capture control bit copies all live counters into a static shadow set in one cycle. A routing bit sends time reads to that shadow, so a read of several bytes always sees one consistent instant.

The current time and four one-cycle rollover strobes are exported to a neighbouring block that handles alarms and interrupts.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, day 01, month 01, year 00, weekday 0. The control register reads 0x00, so the clock is halted.
- R2: Time fields sit at byte offsets 0x00 seconds, 0x01 minutes, 0x02 hours, 0x03 day of month, 0x04 month, 0x05 year, 0x06 weekday. Each holds packed BCD with the tens in bits 7:4. Read data appears on rdata_o in the cycle after a read request.
- R3: Seconds advance only while control bit 0 (offset 0x0D) is 1. One second elapses on every TICKS_PER_SEC-th tick pulse, and tick pulses are not counted while the clock is halted.
- R4: Seconds and minutes count 00 to 59 and carry. sec_roll_o, min_roll_o, hour_roll_o and day_roll_o each pulse for one cycle. The pulse falls in the same cycle that the wrapped seconds, minutes, hours or day-of-month value first shows on the outputs.
- R5: In 24-hour mode (control bit 3 = 0), hours count 00 to 23. The step from 23 to 00 advances the day.
- R6: In 12-hour mode (control bit 3 = 1), hours hold BCD 01 to 12 in bits 4:0 and a PM flag in bit 7. The sequence is 12, 01 … 11. Going from 11 AM to 12 PM does not advance the day. Going from 11 PM to 12 AM does advance the day and pulses hour_roll_o.
- R7: The day of month wraps to 01 after 30 in April, June, September and November. It wraps after 28 in February, or after 29 when the year is divisible by 4, and after 31 otherwise. Month wraps from 12 to 01 and increments the year. Year wraps from 99 to 00.
- R8: The weekday counts 0 to 6 and wraps to 0. It advances each time the day advances.
- R9: Writing control bit 6 = 1 copies all seven live fields into the shadow set. Bit 6 is not stored and reads 0. The other control bits read back as written.
- R10: With control bit 7 = 1, reads of offsets 0x00–0x06 return the shadow set. With bit 7 = 0 they return the live fields.
- R11: An access with burst_i = 1 ignores addr_i and uses the previous access address plus one.
- R12: A write to any time field takes effect at once, even while the clock is counting. The same write restarts the tick prescaler, so the next second needs a full TICKS_PER_SEC ticks.
- R13: Writes to offsets other than 0x00–0x06 and 0x0D change nothing. Reads of those offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaler tick pulse, one cycle per tick |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Access is a write |
| burst_i | input | 1 | Use previous address plus one |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after a read |
| sec_o | output | 8 | Live seconds, BCD |
| min_o | output | 8 | Live minutes, BCD |
| hour_o | output | 8 | Live hours, BCD (PM flag in bit 7 in 12-hour mode) |
| mday_o | output | 8 | Live day of month, BCD |
| mon_o | output | 8 | Live month, BCD |
| year_o | output | 8 | Live year, BCD |
| wday_o | output | 8 | Live weekday, 0 to 6 |
| sec_roll_o | output | 1 | Seconds wrapped |
| min_roll_o | output | 1 | Minutes wrapped |
| hour_roll_o | output | 1 | Hours wrapped to the start of a day |
| day_roll_o | output | 1 | Day of month wrapped to 01 |

## Verification
The bench builds the core with TICKS_PER_SEC = 4 and ADDR_W = 5. A simulated second therefore costs eight clock cycles, and the prescaler restart is visible after only a few ticks. Every carry boundary is reached by loading times just before it: end of minute, hour and day in both hour modes, month ends of every length, leap and non-leap Februaries, and the year 99 wrap. Random starts are biased toward those boundaries and then run for up to 70 seconds.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned NUM_FIELDS = 7;
  localparam int unsigned IDX_SEC    = 0;
  localparam int unsigned IDX_MIN    = 1;
  localparam int unsigned IDX_HOUR   = 2;
  localparam int unsigned IDX_MDAY   = 3;
  localparam int unsigned IDX_MON    = 4;
  localparam int unsigned IDX_YEAR   = 5;
  localparam int unsigned IDX_WDAY   = 6;
  localparam int unsigned CTRL_OFS   = 13;
  localparam int unsigned CB_RUN     = 0;
  localparam int unsigned CB_MODE12  = 3;
  localparam int unsigned CB_CAPTURE = 6;
  localparam int unsigned CB_SHADOW  = 7;

  typedef logic [NUM_FIELDS-1:0][BYTE_W-1:0] fields_t;

  // reset: day 01, month 01, all else zero
  localparam fields_t FIELDS_RST = 56'h00_00_01_01_00_00_00;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'h9) ? {v[7:4] + 4'h1, 4'h0} : {v[7:4], v[3:0] + 4'h1};
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    logic [7:0] bin;
    bin = 8'(y[7:4] * 4'd10) + {4'h0, y[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] year);
    case (mon)
      8'h02:                      return is_leap(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic clr_i,
  output logic sec_evt_o
);
  localparam int unsigned PRE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

  logic [PRE_W-1:0] cnt_q;
  logic             last;

  assign last      = (cnt_q == PRE_W'(TICKS_PER_SEC - 1));
  assign sec_evt_o = tick_i & run_i & ~clr_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (tick_i && run_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_bcd_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  adv_i,
  input  logic                  mode12_i,
  input  logic [NUM_FIELDS-1:0] wr_en_i,
  input  logic [BYTE_W-1:0]     wr_data_i,
  output fields_t               now_o,
  output logic [3:0]            roll_o
);
  fields_t    fld_q, nxt;
  logic [3:0] roll_q;
  logic       step, sec_c, min_c, hr_wrap, hr_c, day_c, mon_c;
  logic [7:0] sec, min, hour, mday, mon, year, wday, h12;

  assign sec  = fld_q[IDX_SEC];
  assign min  = fld_q[IDX_MIN];
  assign hour = fld_q[IDX_HOUR];
  assign mday = fld_q[IDX_MDAY];
  assign mon  = fld_q[IDX_MON];
  assign year = fld_q[IDX_YEAR];
  assign wday = fld_q[IDX_WDAY];
  assign h12  = {3'b000, hour[4:0]};
  assign step = adv_i & ~(|wr_en_i);

  always_comb begin
    nxt   = fld_q;
    sec_c = (sec == 8'h59);
    min_c = sec_c & (min == 8'h59);
    nxt[IDX_SEC] = sec_c ? 8'h00 : bcd_inc(sec);
    if (sec_c) nxt[IDX_MIN] = (min == 8'h59) ? 8'h00 : bcd_inc(min);
    // hours: 12-hour mode flips PM at 11->12, wraps the day only when leaving PM
    if (mode12_i) begin
      hr_wrap = (h12 == 8'h11) & hour[7];
      if (h12 == 8'h11)      nxt[IDX_HOUR] = {~hour[7], 7'h12};
      else if (h12 == 8'h12) nxt[IDX_HOUR] = {hour[7], 7'h01};
      else                   nxt[IDX_HOUR] = {hour[7], bcd_inc(h12)[6:0]};
    end else begin
      hr_wrap = (hour == 8'h23);
      nxt[IDX_HOUR] = hr_wrap ? 8'h00 : bcd_inc(hour);
    end
    if (!min_c) nxt[IDX_HOUR] = hour;
    hr_c  = min_c & hr_wrap;
    day_c = hr_c & (mday == month_len(mon, year));
    mon_c = day_c & (mon == 8'h12);
    if (hr_c)  nxt[IDX_MDAY] = day_c ? 8'h01 : bcd_inc(mday);
    if (hr_c)  nxt[IDX_WDAY] = (wday == 8'h06) ? 8'h00 : bcd_inc(wday);
    if (day_c) nxt[IDX_MON]  = (mon == 8'h12) ? 8'h01 : bcd_inc(mon);
    if (mon_c) nxt[IDX_YEAR] = (year == 8'h99) ? 8'h00 : bcd_inc(year);
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         fld_q[i] <= FIELDS_RST[i];
      else if (wr_en_i[i]) fld_q[i] <= wr_data_i;
      else if (step)       fld_q[i] <= nxt[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) roll_q <= '0;
    else         roll_q <= step ? {day_c, hr_c, min_c, sec_c} : 4'b0000;
  end

  assign now_o  = fld_q;
  assign roll_o = roll_q;
endmodule

// File: rtl/rtc_reg_port.sv
module rtc_reg_port
  import rtc_bcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic                  burst_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  input  fields_t               live_i,
  output logic [BYTE_W-1:0]     rdata_o,
  output logic                  run_o,
  output logic                  mode12_o,
  output logic [NUM_FIELDS-1:0] time_we_o
);
  localparam int unsigned IDX_W = $clog2(NUM_FIELDS);

  logic [ADDR_W-1:0] ptr_q, eff_addr;
  logic [BYTE_W-1:0] ctrl_q, rd_val, rdata_q;
  fields_t           shadow_q;
  logic              ctrl_we, capture;

  assign eff_addr = burst_i ? ptr_q : addr_i;
  assign ctrl_we  = req_i & we_i & (eff_addr == ADDR_W'(CTRL_OFS));
  assign capture  = ctrl_we & wdata_i[CB_CAPTURE];

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_we
    assign time_we_o[i] = req_i & we_i & (eff_addr == ADDR_W'(i));
  end

  always_comb begin
    rd_val = '0;
    if (eff_addr < ADDR_W'(NUM_FIELDS))
      rd_val = ctrl_q[CB_SHADOW] ? shadow_q[eff_addr[IDX_W-1:0]] : live_i[eff_addr[IDX_W-1:0]];
    else if (eff_addr == ADDR_W'(CTRL_OFS))
      rd_val = ctrl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      ctrl_q   <= '0;
      rdata_q  <= '0;
      shadow_q <= FIELDS_RST;
    end else begin
      if (req_i)          ptr_q   <= eff_addr + 1'b1;
      if (req_i && !we_i) rdata_q <= rd_val;
      if (ctrl_we) begin
        ctrl_q             <= wdata_i;
        ctrl_q[CB_CAPTURE] <= 1'b0;
      end
      if (capture) shadow_q <= live_i;
    end
  end

  assign rdata_o  = rdata_q;
  assign run_o    = ctrl_q[CB_RUN];
  assign mode12_o = ctrl_q[CB_MODE12];
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_bcd_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned ADDR_W        = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              burst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [7:0]        sec_o,
  output logic [7:0]        min_o,
  output logic [7:0]        hour_o,
  output logic [7:0]        mday_o,
  output logic [7:0]        mon_o,
  output logic [7:0]        year_o,
  output logic [7:0]        wday_o,
  output logic              sec_roll_o,
  output logic              min_roll_o,
  output logic              hour_roll_o,
  output logic              day_roll_o
);
  fields_t               now;
  logic [NUM_FIELDS-1:0] time_we;
  logic [3:0]            roll;
  logic                  run_w, mode12, sec_evt, time_wr_w;

  assign time_wr_w = |time_we;

  rtc_reg_port #(.ADDR_W(ADDR_W)) u_port (
    .clk_i, .rst_ni, .req_i, .we_i, .burst_i, .addr_i, .wdata_i,
    .live_i(now), .rdata_o, .run_o(run_w), .mode12_o(mode12), .time_we_o(time_we)
  );

  rtc_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk_i, .rst_ni, .tick_i, .run_i(run_w), .clr_i(time_wr_w), .sec_evt_o(sec_evt)
  );

  rtc_time_chain u_chain (
    .clk_i, .rst_ni, .adv_i(sec_evt), .mode12_i(mode12), .wr_en_i(time_we),
    .wr_data_i(wdata_i), .now_o(now), .roll_o(roll)
  );

  assign sec_o       = now[IDX_SEC];
  assign min_o       = now[IDX_MIN];
  assign hour_o      = now[IDX_HOUR];
  assign mday_o      = now[IDX_MDAY];
  assign mon_o       = now[IDX_MON];
  assign year_o      = now[IDX_YEAR];
  assign wday_o      = now[IDX_WDAY];
  assign sec_roll_o  = roll[0];
  assign min_roll_o  = roll[1];
  assign hour_roll_o = roll[2];
  assign day_roll_o  = roll[3];
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_i,
  input logic       time_wr_i,
  input logic [7:0] sec_i,
  input logic [7:0] min_i,
  input logic [7:0] hour_i,
  input logic [7:0] mday_i,
  input logic [7:0] mon_i,
  input logic [7:0] year_i,
  input logic [7:0] wday_i,
  input logic       sec_roll_i,
  input logic       min_roll_i,
  input logic       hour_roll_i,
  input logic       day_roll_i
);
  assert_halt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !time_wr_i) |=> $stable({sec_i, min_i, hour_i, mday_i, mon_i, year_i, wday_i}));

  assert_sec_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_roll_i |-> (sec_i == 8'h00) && ($past(sec_i) == 8'h59));

  assert_roll_nest_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (min_roll_i |-> sec_roll_i) and (hour_roll_i |-> min_roll_i) and (day_roll_i |-> hour_roll_i));

  assert_day_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_roll_i |-> (mday_i == 8'h01));

  assert_wday_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hour_roll_i |-> (wday_i == (($past(wday_i) == 8'h06) ? 8'h00 : $past(wday_i) + 8'h01)));
endmodule

bind rtc_bcd_core rtc_bcd_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_w), .time_wr_i(time_wr_w),
  .sec_i(sec_o), .min_i(min_o), .hour_i(hour_o), .mday_i(mday_o), .mon_i(mon_o),
  .year_i(year_o), .wday_i(wday_o), .sec_roll_i(sec_roll_o), .min_roll_i(min_roll_o),
  .hour_roll_i(hour_roll_o), .day_roll_i(day_roll_o)
);

// File: tb/rtc_bcd_core_tb_top.sv
`timescale 1ns/1ps
module rtc_bcd_core_tb_top;
  localparam int TPS = 4;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic       req = 1'b0, we = 1'b0, burst = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, sec, min, hour, mday, mon, year, wday;
  logic       r_sec, r_min, r_hour, r_day;

  rtc_bcd_core #(.TICKS_PER_SEC(TPS), .ADDR_W(5)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we), .burst_i(burst),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .sec_o(sec), .min_o(min),
    .hour_o(hour), .mday_o(mday), .mon_o(mon), .year_o(year), .wday_o(wday),
    .sec_roll_o(r_sec), .min_roll_o(r_min), .hour_roll_o(r_hour), .day_roll_o(r_day)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_s, m_mi, m_h, m_d, m_mo, m_y, m_w;
  bit m12;
  logic [3:0] exp_roll, got_roll;

  function automatic logic [7:0] b2d(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mlen(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] enc_hour(int h24, bit twelve);
    int h;
    if (!twelve) return b2d(h24);
    h = h24 % 12;
    if (h == 0) h = 12;
    return (h24 >= 12 ? 8'h80 : 8'h00) | b2d(h);
  endfunction

  function automatic logic [55:0] exp_vec();
    return {b2d(m_w), b2d(m_y), b2d(m_mo), b2d(m_d), enc_hour(m_h, m12), b2d(m_mi), b2d(m_s)};
  endfunction

  function automatic logic [55:0] act_vec();
    return {wday, year, mon, mday, hour, min, sec};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    exp_roll = 4'b0000;
    m_s++;
    if (m_s == 60) begin
      m_s = 0; exp_roll[0] = 1; m_mi++;
      if (m_mi == 60) begin
        m_mi = 0; exp_roll[1] = 1; m_h++;
        if (m_h == 24) begin
          m_h = 0; exp_roll[2] = 1; m_w = (m_w + 1) % 7; m_d++;
          if (m_d > mlen(m_mo, m_y)) begin
            m_d = 1; exp_roll[3] = 1; m_mo++;
            if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic acc(input bit w, input bit b, input logic [4:0] a, input logic [7:0] d,
                     output logic [7:0] q);
    @(negedge clk);
    req = 1; we = w; burst = b; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; burst = 0;
    q = rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] q;
    acc(1, 0, a, d, q);
  endtask

  task automatic set_ctrl(bit run, bit twelve, bit sel, bit cap);
    m12 = twelve;
    wr(5'h0D, {sel, cap, 2'b00, twelve, 2'b00, run});
  endtask

  task automatic set_time(int s, int mi, int h, int d, int mo, int y, int w);
    logic [7:0] q;
    m_s = s; m_mi = mi; m_h = h; m_d = d; m_mo = mo; m_y = y; m_w = w;
    acc(1, 0, 5'h00, b2d(s), q);
    acc(1, 1, 5'h1F, b2d(mi), q);
    acc(1, 1, 5'h1F, enc_hour(h, m12), q);
    acc(1, 1, 5'h1F, b2d(d), q);
    acc(1, 1, 5'h1F, b2d(mo), q);
    acc(1, 1, 5'h1F, b2d(y), q);
    acc(1, 1, 5'h1F, b2d(w), q);
  endtask

  task automatic tick_once();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    got_roll = {r_day, r_hour, r_min, r_sec};
  endtask

  task automatic one_second(string tag);
    for (int i = 0; i < TPS; i++) tick_once();
    model_step();
    check({tag, " time"}, 64'(act_vec()), 64'(exp_vec()));
    check({tag, " strobes R4"}, 64'(got_roll), 64'(exp_roll));
  endtask

  task automatic burst_read(string tag, logic [55:0] exp);
    logic [7:0]  q;
    logic [55:0] got;
    for (int i = 0; i < 7; i++) begin
      acc(0, i != 0, 5'h00, 8'h00, q);
      got[i*8 +: 8] = q;
    end
    check(tag, 64'(got), 64'(exp));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  q;
    logic [55:0] snap;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_mo = 1; m_y = 0; m_w = 0; m12 = 0;

    // R1 reset state
    check("R1 reset fields", 64'(act_vec()), 64'(56'h00_00_01_01_00_00_00));
    acc(0, 0, 5'h0D, 8'h00, q);
    check("R1 reset ctrl", 64'(q), 64'h00);

    // R3 halted: ticks ignored
    for (int i = 0; i < 2 * TPS; i++) tick_once();
    check("R3 halted hold", 64'(act_vec()), 64'(exp_vec()));
    set_ctrl(1, 0, 0, 0);
    for (int i = 0; i < TPS - 1; i++) tick_once();
    check("R3 partial second", 64'(act_vec()), 64'(exp_vec()));
    tick_once(); model_step();
    check("R3 first second", 64'(act_vec()), 64'(exp_vec()));

    // R2 single reads of each offset
    set_time(37, 42, 19, 15, 8, 31, 3);
    for (int i = 0; i < 7; i++) begin
      acc(0, 0, 5'(i), 8'h00, q);
      check("R2 field read", 64'(q), 64'(exp_vec() >> (8 * i)) & 64'hFF);
    end

    // R12 prescaler restarts on time write
    tick_once(); tick_once();
    wr(5'h00, 8'h30); m_s = 30;
    for (int i = 0; i < TPS - 1; i++) tick_once();
    check("R12 prescaler restart hold", 64'(act_vec()), 64'(exp_vec()));
    tick_once(); model_step();
    check("R12 advance after full count", 64'(act_vec()), 64'(exp_vec()));

    // R5 R7 R8 24h boundaries
    set_time(59, 59, 23, 28, 2, 24, 6); one_second("R5 R7 R8 leap Feb 28");
    set_time(59, 59, 23, 29, 2, 24, 2); one_second("R7 leap Feb 29");
    set_time(59, 59, 23, 28, 2, 23, 1); one_second("R7 plain Feb 28");
    set_time(59, 59, 23, 30, 4, 10, 4); one_second("R7 April 30");
    set_time(59, 59, 23, 30, 5, 10, 4); one_second("R7 May 30 no wrap");
    set_time(59, 59, 23, 31, 12, 99, 5); one_second("R7 year 99 wrap");
    set_time(59, 59, 22, 31, 1, 50, 0); one_second("R5 hour 22 to 23");

    // R6 12-hour mode
    set_ctrl(1, 1, 0, 0);
    set_time(59, 59, 11, 10, 3, 20, 1); one_second("R6 11AM to 12PM");
    set_time(59, 59, 12, 10, 3, 20, 1); one_second("R6 12PM to 1PM");
    set_time(59, 59, 23, 31, 3, 20, 6); one_second("R6 11PM to 12AM");
    set_time(59, 59, 0, 5, 3, 20, 1);   one_second("R6 12AM to 1AM");
    set_ctrl(1, 0, 0, 0);

    // R9 R10 R11 capture and shadow routing
    set_time(58, 59, 23, 31, 12, 7, 3);
    set_ctrl(1, 0, 0, 1);
    snap = exp_vec();
    for (int i = 0; i < 3; i++) one_second("R9 run after capture");
    set_ctrl(1, 0, 1, 0);
    burst_read("R10 R11 shadow burst read", snap);
    acc(0, 0, 5'h0D, 8'h00, q);
    check("R9 ctrl bit6 reads 0", 64'(q), 64'h81);
    set_ctrl(1, 0, 0, 0);
    burst_read("R10 live burst read", exp_vec());
    set_ctrl(1, 0, 1, 1);
    burst_read("R9 recapture", exp_vec());
    set_ctrl(1, 0, 0, 0);

    // R13 unmapped offsets
    wr(5'h08, 8'h55);
    wr(5'h1E, 8'hAA);
    acc(0, 0, 5'h08, 8'h00, q);
    check("R13 unmapped read", 64'(q), 64'h00);
    check("R13 fields untouched", 64'(act_vec()), 64'(exp_vec()));
    acc(0, 0, 5'h0D, 8'h00, q);
    check("R13 ctrl untouched", 64'(q), 64'h01);

    // random starts biased toward rollover
    for (int it = 0; it < 25; it++) begin
      int s, mi, h, mo, y, d, n;
      set_ctrl(1, bit'($urandom % 2), 0, 0);
      s  = ($urandom % 2) ? 50 + $urandom % 10 : $urandom % 60;
      mi = ($urandom % 2) ? 59 : $urandom % 60;
      h  = ($urandom % 3 == 0) ? $urandom % 24 : (($urandom % 2) ? 23 : 11);
      mo = 1 + $urandom % 12;
      y  = ($urandom % 4 == 0) ? 99 : $urandom % 100;
      d  = mlen(mo, y) - $urandom % 2;
      set_time(s, mi, h, d, mo, y, $urandom % 7);
      n = 1 + $urandom % 70;
      for (int k = 0; k < n; k++) one_second("R4 R5 R6 R7 R8 random");
      burst_read("R2 R11 random readback", exp_vec());
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule